// File: doc/BRIEF.md
# Bus Error Reporting Unit

This unit keeps the error bookkeeping of a bus bridge function. It holds an 8-bit error-enable register and an 8-bit sticky error-status register, and it turns two kinds of failure into one system-error request. The first failure is a target abort seen by the bridge. The second is a stale delayed transaction: once the bridge has completed a cycle on behalf of a requesting master, an internal timer runs until that master comes back for its data. If the master does not return within the timeout window, the unit tells the surrounding logic to drop the buffered transaction and records the event.

Software reads and writes both registers through a simple single-cycle register port. Status bits are set by hardware and cleared by software writing 1. A source raises the system-error request only when its status bit is set, its own enable bit is set, and the chip-level error-reporting enable input is high. The request is a registered, active-high level.

Top module: `err_report_unit`

## Requirements
- R1: During and after reset, both registers read 00h, `serr_req` is 0 and `dt_discard` is 0.
- R2: The enable register sits at address 88h. Bit 2 (target-abort enable) and bit 1 (stale-transaction enable) are read/write. Bits 7:3 and bit 0 always read 0. Any address other than 88h and 8Ah reads 00h, and writes to it change no state.
- R3: A cycle with `target_abort` high sets status bit 2 (address 8Ah) at that clock edge. The bit then stays set until software clears it.
- R4: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged. A status write never sets a bit, and bits 7:3 and 0 read 0.
- R5: When a hardware set and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R6: Writing the enable register never changes the status register.
- R7: The timer starts on the edge that samples `dt_data_ready`. If `dt_retrieved` is not sampled afterwards, `dt_discard` is high for exactly one cycle, following the TIMEOUT_CYCLES-th edge after the start. Status bit 1 sets on the next edge.
- R8: If `dt_retrieved` is sampled on any edge up to and including that final edge, the timer stops. No discard pulse follows and status bit 1 is not set.
- R9: A new `dt_data_ready` while the timer is running restarts the count from zero.
- R10: `serr_req` is registered. One edge after the inputs are sampled, it equals `serr_global_en` AND ((status bit 2 AND enable bit 2) OR (status bit 1 AND enable bit 1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address, used for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| target_abort | input | 1 | Target abort received this cycle |
| dt_data_ready | input | 1 | Delayed transaction completed; data waits for the master |
| dt_retrieved | input | 1 | The master has collected its delayed data |
| serr_global_en | input | 1 | Chip-level system-error reporting enable |
| serr_req | output | 1 | System-error request level |
| dt_discard | output | 1 | One-cycle request to free the stale transaction buffer |

## Verification
Two pairs of functions can land on the same edge. The first pair is a hardware set of a status bit and a software write-1 clear of that same bit. The bench drives `target_abort` together with a clearing status write and expects the bit to read back as set. The second pair is the master's retrieval and the timer's final count. The bench sweeps the retrieval over every edge from the first one to one past the limit. It expects a discard pulse, and a set status bit 1, only when the retrieval comes after the last counted edge.

// File: rtl/err_report_pkg.sv
package err_report_pkg;

    // register geometry
    localparam int REG_W   = 8;
    localparam int N_SRC   = 2;
    // bit positions of each source inside both registers
    localparam int BIT_TA  = 2;
    localparam int BIT_DTT = 1;
    // index of each source inside a packed source vector
    localparam int IDX_TA  = 1;
    localparam int IDX_DTT = 0;

    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << BIT_TA) | (REG_W'(1) << BIT_DTT);

    // one flag per error source
    typedef struct packed {
        logic ta;   // target abort
        logic dtt;  // stale delayed transaction
    } err_pair_t;

    typedef enum logic [0:0] {
        DT_IDLE = 1'b0,
        DT_WAIT = 1'b1
    } dt_state_e;

    function automatic logic [REG_W-1:0] pair_to_reg(input err_pair_t p);
        logic [REG_W-1:0] r;
        r          = '0;
        r[BIT_TA]  = p.ta;
        r[BIT_DTT] = p.dtt;
        return r;
    endfunction

    function automatic err_pair_t reg_to_pair(input logic [REG_W-1:0] r);
        err_pair_t p;
        p.ta  = r[BIT_TA];
        p.dtt = r[BIT_DTT];
        return p;
    endfunction

    function automatic logic pair_overlap(input err_pair_t a, input err_pair_t b);
        return (a.ta & b.ta) | (a.dtt & b.dtt);
    endfunction

endpackage

// File: rtl/err_cfg_bank.sv
module err_cfg_bank
    import err_report_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  err_pair_t wr_pair,
    output err_pair_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            cfg_q <= wr_pair;
        end
    end

endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank
    import err_report_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_pair_t set_evt,
    input  logic      clr_hit,
    input  err_pair_t clr_pair,
    output err_pair_t sts_q
);

    logic [N_SRC-1:0] set_v;
    logic [N_SRC-1:0] clr_v;
    logic [N_SRC-1:0] cur_v;
    logic [N_SRC-1:0] nxt_v;

    assign set_v = set_evt;
    assign clr_v = clr_hit ? clr_pair : '0;
    assign cur_v = sts_q;

    // per-source sticky cell: a set beats a clear on the same edge
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        always_comb begin
            if (set_v[i]) begin
                nxt_v[i] = 1'b1;
            end else if (clr_v[i]) begin
                nxt_v[i] = 1'b0;
            end else begin
                nxt_v[i] = cur_v[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= nxt_v;
        end
    end

endmodule

// File: rtl/dt_discard_timer.sv
module dt_discard_timer
    import err_report_pkg::*;
#(
    parameter int LIMIT = 33000
) (
    input  logic clk,
    input  logic rst,
    input  logic data_ready,
    input  logic retrieved,
    output logic discard_o
);

    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    dt_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    // expiry only when nothing else is sampled on the final edge
    assign fire = (state_q == DT_WAIT) && !retrieved && !data_ready && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= DT_IDLE;
            cnt_q     <= '0;
            discard_o <= 1'b0;
        end else begin
            discard_o <= fire;
            if (data_ready) begin
                state_q <= DT_WAIT;
                cnt_q   <= '0;
            end else if (state_q == DT_WAIT) begin
                if (retrieved || fire) begin
                    state_q <= DT_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/serr_gate.sv
module serr_gate
    import err_report_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_pair_t sts,
    input  err_pair_t cfg,
    input  logic      global_en,
    output logic      serr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            serr_o <= 1'b0;
        end else begin
            serr_o <= global_en & pair_overlap(sts, cfg);
        end
    end

endmodule

// File: rtl/err_report_unit.sv
module err_report_unit
    import err_report_pkg::*;
#(
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR       = ADDR_W'(8'h88),
    parameter logic [ADDR_W-1:0] STS_ADDR       = ADDR_W'(8'h8A),
    parameter int                TIMEOUT_CYCLES = 33000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              target_abort,
    input  logic              dt_data_ready,
    input  logic              dt_retrieved,
    input  logic              serr_global_en,
    output logic              serr_req,
    output logic              dt_discard
);

    err_pair_t cfg_pair;
    err_pair_t sts_pair;
    err_pair_t wr_pair;
    err_pair_t evt_pair;
    logic      cfg_hit;
    logic      sts_hit;
    logic      unused_wbits;

    assign wr_pair      = reg_to_pair(reg_wdata);
    assign unused_wbits = ^(reg_wdata & ~LIVE_MASK);
    assign cfg_hit      = reg_wr && (reg_addr == CFG_ADDR);
    assign sts_hit      = reg_wr && (reg_addr == STS_ADDR);

    assign evt_pair.ta  = target_abort;
    assign evt_pair.dtt = dt_discard;

    err_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (cfg_hit),
        .wr_pair (wr_pair),
        .cfg_q   (cfg_pair)
    );

    err_sticky_bank u_sts (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (evt_pair),
        .clr_hit  (sts_hit),
        .clr_pair (wr_pair),
        .sts_q    (sts_pair)
    );

    dt_discard_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .data_ready (dt_data_ready),
        .retrieved  (dt_retrieved),
        .discard_o  (dt_discard)
    );

    serr_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .sts       (sts_pair),
        .cfg       (cfg_pair),
        .global_en (serr_global_en),
        .serr_o    (serr_req)
    );

    always_comb begin
        if (reg_addr == CFG_ADDR) begin
            reg_rdata = pair_to_reg(cfg_pair);
        end else if (reg_addr == STS_ADDR) begin
            reg_rdata = pair_to_reg(sts_pair);
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/err_report_chk.sv
module err_report_chk
    import err_report_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8'h88),
    parameter logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(8'h8A)
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              target_abort,
    input logic              dt_data_ready,
    input logic              dt_retrieved,
    input logic              serr_global_en,
    input logic              serr_req,
    input logic              dt_discard,
    input err_pair_t         sts_pair,
    input err_pair_t         cfg_pair
);

    logic sts_clr_ta;
    logic cfg_wr;
    assign sts_clr_ta = reg_wr && (reg_addr == STS_ADDR) && reg_wdata[BIT_TA];
    assign cfg_wr     = reg_wr && (reg_addr == CFG_ADDR);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!serr_req && !dt_discard));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE_MASK) == '0);

    // R3
    ta_sets_chk: assert property (@(posedge clk) disable iff (rst)
        target_abort |=> sts_pair.ta);

    // R4
    ta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_pair.ta && !sts_clr_ta) |=> sts_pair.ta);

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_clr_ta && !target_abort) |=> !sts_pair.ta);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_clr_ta && target_abort) |=> sts_pair.ta);

    // R6
    cfg_keeps_sts_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !target_abort && !dt_discard) |=> $stable(sts_pair));

    // R7
    discard_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dt_discard |=> !dt_discard);

    // R7
    discard_sets_chk: assert property (@(posedge clk) disable iff (rst)
        dt_discard |=> sts_pair.dtt);

    // R8
    retrieve_cancels_chk: assert property (@(posedge clk) disable iff (rst)
        (dt_retrieved && !dt_data_ready) |=> !dt_discard);

    // R10
    serr_gen_off_chk: assert property (@(posedge clk) disable iff (rst)
        !serr_global_en |=> !serr_req);

    // R10
    serr_ta_chk: assert property (@(posedge clk) disable iff (rst)
        (serr_global_en && sts_pair.ta && cfg_pair.ta) |=> serr_req);

    // R10
    serr_dtt_chk: assert property (@(posedge clk) disable iff (rst)
        (serr_global_en && sts_pair.dtt && cfg_pair.dtt) |=> serr_req);

    logic unused_chk;
    assign unused_chk = ^{dt_data_ready, reg_wdata};

endmodule

bind err_report_unit err_report_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR),
    .STS_ADDR (STS_ADDR)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .target_abort   (target_abort),
    .dt_data_ready  (dt_data_ready),
    .dt_retrieved   (dt_retrieved),
    .serr_global_en (serr_global_en),
    .serr_req       (serr_req),
    .dt_discard     (dt_discard),
    .sts_pair       (sts_pair),
    .cfg_pair       (cfg_pair)
);

// File: tb/err_report_unit_tb.sv
module err_report_unit_tb;

    localparam int         TO      = 20;
    localparam logic [7:0] A_CFG   = 8'h88;
    localparam logic [7:0] A_STS   = 8'h8A;
    localparam logic [7:0] A_OTHER = 8'h89;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       target_abort = 1'b0;
    logic       dt_data_ready = 1'b0;
    logic       dt_retrieved = 1'b0;
    logic       serr_global_en = 1'b0;
    logic       serr_req;
    logic       dt_discard;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    err_report_unit #(
        .ADDR_W         (8),
        .CFG_ADDR       (A_CFG),
        .STS_ADDR       (A_STS),
        .TIMEOUT_CYCLES (TO)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .target_abort   (target_abort),
        .dt_data_ready  (dt_data_ready),
        .dt_retrieved   (dt_retrieved),
        .serr_global_en (serr_global_en),
        .serr_req       (serr_req),
        .dt_discard     (dt_discard)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=200000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse_ta();
        @(negedge clk);
        target_abort = 1'b1;
        @(negedge clk);
        target_abort = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk);
        dt_data_ready = 1'b1;
        @(negedge clk);
        dt_data_ready = 1'b0;
    endtask

    task automatic set_dtt();
        arm();
        repeat (TO + 1) @(negedge clk);
    endtask

    initial begin
        int v;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 serr_req in reset", int'(serr_req), 0);
        rst = 1'b0;
        rd(A_CFG, v); chk("R1 enable reg", v, 0);
        rd(A_STS, v); chk("R1 status reg", v, 0);
        chk("R1 dt_discard", int'(dt_discard), 0);

        // R2 enable register read/write and reserved bits
        wr(A_CFG, 8'hFF); rd(A_CFG, v); chk("R2 write FF", v, 8'h06);
        wr(A_CFG, 8'h04); rd(A_CFG, v); chk("R2 write 04", v, 8'h04);
        wr(A_CFG, 8'h02); rd(A_CFG, v); chk("R2 write 02", v, 8'h02);
        wr(A_OTHER, 8'hFF);
        rd(A_OTHER, v); chk("R2 other addr reads 0", v, 0);
        rd(A_CFG, v);   chk("R2 other addr write ignored", v, 8'h02);
        rd(A_STS, v);   chk("R2 other addr leaves status", v, 0);
        wr(A_CFG, 8'h00);

        // R4 status write never sets
        wr(A_STS, 8'hFF); rd(A_STS, v); chk("R4 write cannot set", v, 0);

        // R3 target abort sets, sticky
        pulse_ta();
        rd(A_STS, v); chk("R3 ta sets bit2", v, 8'h04);
        repeat (5) @(negedge clk);
        rd(A_STS, v); chk("R3 ta sticky", v, 8'h04);

        // R4 write 0 no effect, write 1 clears
        wr(A_STS, 8'hF9); rd(A_STS, v); chk("R4 write 0 keeps", v, 8'h04);
        wr(A_STS, 8'h04); rd(A_STS, v); chk("R4 write 1 clears", v, 0);

        // R5 set and clear on same edge
        @(negedge clk);
        target_abort = 1'b1;
        reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 8'h04;
        @(negedge clk);
        target_abort = 1'b0; reg_wr = 1'b0;
        rd(A_STS, v); chk("R5 set wins", v, 8'h04);
        wr(A_STS, 8'h06);

        // R7 timeout pulse timing
        arm();
        for (int j = 1; j <= TO + 1; j++) begin
            @(negedge clk);
            chk("R7 discard timing", int'(dt_discard), (j == TO) ? 1 : 0);
            rd(A_STS, v);
            chk("R7 status bit1 timing", v, (j == TO + 1) ? 8'h02 : 0);
        end
        wr(A_STS, 8'h02); rd(A_STS, v); chk("R4 clear bit1", v, 0);

        // R8 retrieval sweep over every edge
        for (int r = 1; r <= TO + 1; r++) begin
            arm();
            for (int j = 1; j <= TO + 2; j++) begin
                dt_retrieved = (j == r);
                @(negedge clk);
                dt_retrieved = 1'b0;
                chk("R8 discard vs retrieval", int'(dt_discard),
                    (r > TO && j == TO) ? 1 : 0);
            end
            rd(A_STS, v);
            chk("R8 status after retrieval", v, (r > TO) ? 8'h02 : 0);
            wr(A_STS, 8'h02);
        end

        // R9 restart
        arm();
        for (int j = 1; j <= TO + 6; j++) begin
            dt_data_ready = (j == 5);
            @(negedge clk);
            dt_data_ready = 1'b0;
            chk("R9 restart timing", int'(dt_discard), (j == 5 + TO) ? 1 : 0);
        end
        wr(A_STS, 8'h02);

        // R10 / R6 sweep: enables x global x status
        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 2; g++) begin
                for (int s = 0; s < 4; s++) begin
                    wr(A_STS, 8'h06);
                    wr(A_CFG, 8'(c << 1));
                    serr_global_en = (g != 0);
                    if ((s & 2) != 0) pulse_ta();
                    if ((s & 1) != 0) set_dtt();
                    @(negedge clk);
                    @(negedge clk);
                    chk("R10 serr gating", int'(serr_req),
                        (g != 0 && (s & c) != 0) ? 1 : 0);
                    wr(A_CFG, 8'(((~c) & 3) << 1));
                    rd(A_STS, v);
                    chk("R6 enable write keeps status", v, s << 1);
                    serr_global_en = 1'b0;
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule